// File: doc/BRIEF.md
# Delta-Sigma Converter Serial Host Controller

This block is the host side of a synchronous serial link to a 16-bit delta-sigma converter. One transaction is a single chip-select frame. In that frame the block shifts in the 16-bit conversion result, most significant bit first. At the same time it shifts out a 4-bit configuration word on the first four clock pulses. A caller starts a frame with a one-cycle `start` pulse and supplies the four configuration bits alongside it. The block returns the result as a one-cycle `result_valid` strobe with `result_data`.

The block can learn that a conversion has finished in one of two ways, chosen by a parameter:

- **Timer variant:** it counts a fixed conversion window from the end of the previous frame and keeps chip select high until that window has elapsed.
- **Poll variant:** it pulls chip select low with the serial clock held high, and waits until the converter drives its data line low.

The block also keeps a shadow copy of the settings the converter has accepted. From that copy it knows when the converter's reference has powered down. In that case it holds chip select low for a warm-up interval before it starts clocking.

States:

- `ST_IDLE`
- `ST_WAIT_CONV` (timer variant: waiting for the conversion window)
- `ST_WARM` (reference warm-up with chip select low)
- `ST_POLL` (poll variant: clock high, waiting for the data line to go low)
- `ST_SHIFT` (16 clock pulses)
- `ST_FINISH` (one cycle: strobe out, chip select high)

Transitions:

- IDLE→WAIT_CONV on start when the window is still open.
- IDLE or WAIT_CONV→WARM when the reference is off.
- IDLE, WAIT_CONV or WARM→POLL in the poll variant, or →SHIFT in the timer variant.
- POLL→SHIFT when the data line is low.
- SHIFT→FINISH after the sixteenth high phase.
- FINISH→IDLE.

Top module: `adc_link_ctrl`

## Requirements
- R1: During and right after reset, `cs_n` is 1, `busy` and `result_valid` are 0, and `sck` sits at its idle level (0 in the timer variant, 1 in the poll variant).
- R2: The block samples `sdo` on each rising `sck` edge, 16 times per frame, and assembles the bits MSB first. One clock after the 16th high phase ends, `result_valid` is 1 for exactly one cycle with `result_data` equal to the word, and `cs_n` is 1 in that same cycle.
- R3: `sdi` presents `{cfg_en1, cfg_en2, cfg_speed, cfg_sleep}` on the first four rising `sck` edges of the frame, `cfg_en1` first. These values are captured when `start` is accepted.
- R4: Timer variant: `cs_n` falls only after at least `CONV_CYCLES` clocks have passed since the previous frame ended (or since reset).
- R5: Poll variant: after `cs_n` falls, `sck` stays high until `sdo` is sampled low; no falling `sck` edge occurs while the converter is still converting.
- R6: A frame's configuration updates the shadow settings only if the enable pair is `cfg_en1`=1 and `cfg_en2`=0. Any other pair leaves the previous settings unchanged, so a sleep request sent with a wrong pair causes no warm-up later.
- R7: An accepted configuration with sleep=1 and speed=0 marks the reference as off. The next frame then holds `cs_n` low for at least `WARM_CYCLES` clocks before the first rising `sck` edge.
- R8: With speed=1 (the slower, calibrated rate) a sleep request has no effect: the next frame has no warm-up wait.
- R9: A `start` pulse while `busy` is 1 is ignored, and no extra frame follows.
- R10: Each `sck` phase during shifting lasts `SCK_HALF` clocks. `sck` never changes while `cs_n` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to run a frame; ignored while busy |
| cfg_en1 | input | 1 | First enable bit of the configuration word |
| cfg_en2 | input | 1 | Second enable bit of the configuration word |
| cfg_speed | input | 1 | Rate select: 0 fast uncalibrated, 1 slow calibrated |
| cfg_sleep | input | 1 | Request reference power-down after the next conversion |
| sdo | input | 1 | Serial data / conversion status from the converter |
| cs_n | output | 1 | Active-low chip select |
| sck | output | 1 | Serial clock to the converter |
| sdi | output | 1 | Serial configuration data to the converter |
| busy | output | 1 | High from an accepted start to the end of the frame |
| result_valid | output | 1 | One-cycle strobe for a completed result |
| result_data | output | 16 | Conversion result, MSB first on the wire |

## Verification
The bench targets the following corner cases, each with the failure it would expose:

- **Edge alignment.** A design off by one `sck` edge would return a shifted word, and it would set the enable bits onto the wrong clock pulse. Words with only the top bit set, only the bottom bit set, all ones and all zeros expose this.
- **Poll variant, top bit set.** The status indication (data line low) must be told apart from the data bit that follows. A controller that confused the two would start clocking early or hang.
- **Shadow settings.** A sleep request sent with a rejected enable pair must not cause a later warm-up; a design that ignored the pair check would wait needlessly. A sleep request at the slower rate must also cause no warm-up. An accepted sleep at the fast rate must cause one; a design that skipped it would clock before the reference settles.
- **Start during a frame.** A start pulse issued mid-frame must not leave a second frame queued.

// File: rtl/adc_link_pkg.sv
package adc_link_pkg;

    localparam int unsigned WORD_BITS = 16;
    localparam int unsigned CFG_BITS  = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_CONV,
        ST_WARM,
        ST_POLL,
        ST_SHIFT,
        ST_FINISH
    } link_state_e;

    // Wire order of the configuration word: en1 leaves first.
    typedef struct packed {
        logic en1;
        logic en2;
        logic speed;
        logic sleep;
    } cfg_word_t;

endpackage

// File: rtl/adc_link_cycle_timer.sv
module adc_link_cycle_timer #(
    parameter int unsigned LIMIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_clear,
    output logic done
);
    localparam int unsigned CW = (LIMIT > 0) ? $clog2(LIMIT + 1) : 1;

    logic [CW-1:0] cnt_q;

    // Counts up from zero and saturates at LIMIT; held at zero while cleared.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (hold_clear) begin
            cnt_q <= '0;
        end else if (cnt_q != CW'(LIMIT)) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign done = (cnt_q == CW'(LIMIT));

endmodule

// File: rtl/adc_link_settings.sv
module adc_link_settings
    import adc_link_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      commit,
    input  cfg_word_t cfg,
    output logic      ref_off
);
    logic speed_q;
    logic sleep_q;
    logic ref_off_q;
    logic accept;

    assign accept = cfg.en1 & ~cfg.en2;

    // Mirrors what the converter holds after each frame. The reference
    // sleeps after the following conversion only at the fast rate.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            speed_q   <= 1'b0;
            sleep_q   <= 1'b0;
            ref_off_q <= 1'b0;
        end else if (commit) begin
            if (accept) begin
                speed_q   <= cfg.speed;
                sleep_q   <= cfg.sleep;
                ref_off_q <= cfg.sleep & ~cfg.speed;
            end else begin
                ref_off_q <= sleep_q & ~speed_q;
            end
        end
    end

    assign ref_off = ref_off_q;

endmodule

// File: rtl/adc_link_ctrl.sv
module adc_link_ctrl
    import adc_link_pkg::*;
#(
    parameter int unsigned SCK_HALF    = 4,
    parameter int unsigned CONV_CYCLES = 2000,
    parameter int unsigned WARM_CYCLES = 1200,
    parameter bit          USE_POLL    = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 cfg_en1,
    input  logic                 cfg_en2,
    input  logic                 cfg_speed,
    input  logic                 cfg_sleep,
    input  logic                 sdo,
    output logic                 cs_n,
    output logic                 sck,
    output logic                 sdi,
    output logic                 busy,
    output logic                 result_valid,
    output logic [WORD_BITS-1:0] result_data
);
    localparam int unsigned HALF_W   = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
    localparam int unsigned BIT_W    = $clog2(WORD_BITS + 1);
    localparam int unsigned CFG_W    = $clog2(CFG_BITS);
    localparam logic        IDLE_SCK = USE_POLL;

    link_state_e          state_q, state_d;
    cfg_word_t            cfg_q;
    logic [CFG_BITS-1:0]  cfg_vec;
    logic [HALF_W-1:0]    half_q;
    logic [BIT_W-1:0]     bits_q;
    logic [BIT_W-1:0]     cfg_pos;
    logic [CFG_W-1:0]     cfg_idx;
    logic                 sck_q;
    logic [WORD_BITS-1:0] shreg_q;
    logic                 conv_ready;
    logic                 warm_done;
    logic                 ref_off;
    logic                 half_end;
    logic                 shift_end;
    logic                 polling;

    assign half_end  = (half_q == HALF_W'(SCK_HALF - 1));
    assign shift_end = sck_q & half_end & (bits_q == BIT_W'(WORD_BITS));
    assign polling   = (state_q == ST_POLL);
    assign cfg_vec   = cfg_q;

    // Readiness source picked by parameter.
    generate
        if (USE_POLL) begin : g_poll_ready
            assign conv_ready = 1'b1;
        end else begin : g_timer_ready
            adc_link_cycle_timer #(.LIMIT(CONV_CYCLES)) u_conv_timer (
                .clk        (clk),
                .rst_n      (rst_n),
                .hold_clear (state_q == ST_FINISH),
                .done       (conv_ready)
            );
        end
    endgenerate

    adc_link_cycle_timer #(.LIMIT(WARM_CYCLES)) u_warm_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold_clear (state_q != ST_WARM),
        .done       (warm_done)
    );

    adc_link_settings u_settings (
        .clk     (clk),
        .rst_n   (rst_n),
        .commit  (state_q == ST_FINISH),
        .cfg     (cfg_q),
        .ref_off (ref_off)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    if (!conv_ready)  state_d = ST_WAIT_CONV;
                    else if (ref_off) state_d = ST_WARM;
                    else              state_d = USE_POLL ? ST_POLL : ST_SHIFT;
                end
            end
            ST_WAIT_CONV: begin
                if (conv_ready) state_d = ref_off ? ST_WARM : ST_SHIFT;
            end
            ST_WARM: begin
                if (warm_done) state_d = USE_POLL ? ST_POLL : ST_SHIFT;
            end
            ST_POLL: begin
                if (!sdo) state_d = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (shift_end) state_d = ST_FINISH;
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Configuration capture at an accepted start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (state_q == ST_IDLE && start) begin
            cfg_q <= '{en1: cfg_en1, en2: cfg_en2, speed: cfg_speed, sleep: cfg_sleep};
        end
    end

    // Bit clock and shift register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_q  <= '0;
            bits_q  <= '0;
            sck_q   <= 1'b0;
            shreg_q <= '0;
        end else if (state_q != ST_SHIFT) begin
            half_q <= '0;
            bits_q <= '0;
            sck_q  <= 1'b0;
        end else if (half_end) begin
            half_q <= '0;
            sck_q  <= ~sck_q;
            if (!sck_q) begin
                shreg_q <= {shreg_q[WORD_BITS-2:0], sdo};
                bits_q  <= bits_q + BIT_W'(1);
            end
        end else begin
            half_q <= half_q + HALF_W'(1);
        end
    end

    // Position of the configuration bit on the wire: during a high phase the
    // rise count has already advanced, so step back by one.
    assign cfg_pos = bits_q - {{(BIT_W-1){1'b0}}, sck_q};
    assign cfg_idx = CFG_W'(CFG_BITS - 1) - cfg_pos[CFG_W-1:0];

    // Outputs
    always_comb begin
        cs_n         = 1'b0;
        sck          = IDLE_SCK;
        sdi          = 1'b0;
        busy         = 1'b1;
        result_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                cs_n = 1'b1;
                busy = 1'b0;
            end
            ST_WAIT_CONV: cs_n = 1'b1;
            ST_WARM:      cs_n = 1'b0;
            ST_POLL:      cs_n = 1'b0;
            ST_SHIFT: begin
                sck = sck_q;
                if (cfg_pos < BIT_W'(CFG_BITS)) sdi = cfg_vec[cfg_idx];
            end
            ST_FINISH: begin
                cs_n         = 1'b1;
                result_valid = 1'b1;
            end
            default: cs_n = 1'b1;
        endcase
    end

    assign result_data = shreg_q;

endmodule

// File: rtl/adc_link_checker.sv
module adc_link_checker #(
    parameter int unsigned CONV_CYCLES = 1,
    parameter bit          USE_POLL    = 1'b0
) (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic sck,
    input logic sdo,
    input logic result_valid,
    input logic polling
);
    int unsigned high_run;

    // Cycles that chip select has been high since it last rose (or reset).
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       high_run <= 0;
        else if (!cs_n)                   high_run <= 0;
        else if (high_run < 32'hFFFF_FFF0) high_run <= high_run + 1;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            a_r1_reset_idle: assert (cs_n && !result_valid && (sck == USE_POLL))
                else $error("R1 outputs not idle in reset");
        end
    end

    a_r2_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);

    a_r2_valid_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> cs_n);

    a_r4_conv_window: assert property (@(posedge clk) disable iff (!rst_n)
        (!USE_POLL && $fell(cs_n)) |-> (high_run >= CONV_CYCLES));

    a_r5_sck_held: assert property (@(posedge clk) disable iff (!rst_n)
        (polling && sdo) |=> sck);

    a_r10_sck_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n)) |-> $stable(sck));

endmodule

bind adc_link_ctrl adc_link_checker #(
    .CONV_CYCLES (CONV_CYCLES),
    .USE_POLL    (USE_POLL)
) u_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_n         (cs_n),
    .sck          (sck),
    .sdo          (sdo),
    .result_valid (result_valid),
    .polling      (polling)
);

// File: tb/adc_link_ctrl_tb_top.sv
module adc_link_periph_model #(
    parameter int CONV_T = 10,
    parameter bit POLL   = 1'b0,
    parameter int HALF   = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cs_n,
    input  logic        sck,
    input  logic        sdi,
    input  logic [15:0] word_in,
    output logic        sdo,
    output logic        exp_valid,
    output logic [15:0] exp_word,
    output logic [3:0]  cfg_seen,
    output int          lead,
    output int          bad_conv,
    output int          bad_half
);
    logic prev_cs, prev_sck, rose, fell, started, counting, hl_act;
    int conv_left, rises, idx, hl;

    always @(negedge clk) begin
        if (!rst_n) begin
            prev_cs = 1'b1; prev_sck = POLL; conv_left = CONV_T;
            rises = 0; idx = 0; started = 0; lead = 0; counting = 0;
            hl = 0; hl_act = 0; exp_valid = 0; exp_word = '0;
            bad_conv = 0; bad_half = 0; cfg_seen = '0; sdo = 1'b1;
        end else begin
            exp_valid = 1'b0;
            if (conv_left > 0) conv_left--;
            rose = !prev_sck && sck;
            fell = prev_sck && !sck;
            if (prev_cs && !cs_n) begin
                if (!POLL && conv_left != 0) bad_conv++;
                rises = 0; idx = 0; started = 0; lead = 0; counting = 1;
                hl_act = 0; exp_word = word_in; cfg_seen = '0;
            end
            if (!prev_cs && cs_n) begin
                exp_valid = (rises == 16);
                conv_left = CONV_T;
            end
            if (!cs_n) begin
                if (counting) lead++;
                if (rose) begin
                    rises++;
                    counting = 0;
                    if (rises <= 4) cfg_seen[4 - rises] = sdi;
                    hl = 1;
                    hl_act = 1;
                end
                if (fell && rises == 0) started = 1;
                if (fell && rises > 0 && idx < 15) idx++;
                if (POLL && fell && conv_left > 0) bad_conv++;
            end
            if (!rose && sck && hl_act) hl++;
            if (fell && hl_act) begin
                if (hl != HALF) bad_half++;
                hl_act = 0;
            end
            prev_cs = cs_n;
            prev_sck = sck;
            if (cs_n)                   sdo = 1'b1;
            else if (POLL && !started)  sdo = (conv_left > 0);
            else                        sdo = exp_word[15 - idx];
        end
    end
endmodule

module adc_link_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 2;
    localparam int CONV_T     = 60;
    localparam int CONV_P     = 50;
    localparam int WARM       = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_t = 1'b0, start_p = 1'b0;
    logic en1 = 1'b0, en2 = 1'b0, spd = 1'b0, slp = 1'b0;
    logic [15:0] word_t = '0, word_p = '0;

    logic cs_t, sck_t, sdi_t, busy_t, val_t, sdo_t;
    logic cs_p, sck_p, sdi_p, busy_p, val_p, sdo_p;
    logic [15:0] data_t, data_p;
    logic ev_t, ev_p;
    logic [15:0] ew_t, ew_p;
    logic [3:0] cfg_t, cfg_p;
    int lead_t, lead_p, bconv_t, bconv_p, bhalf_t, bhalf_p;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_link_ctrl #(.SCK_HALF(HALF), .CONV_CYCLES(CONV_T), .WARM_CYCLES(WARM), .USE_POLL(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start_t), .cfg_en1(en1), .cfg_en2(en2),
        .cfg_speed(spd), .cfg_sleep(slp), .sdo(sdo_t), .cs_n(cs_t), .sck(sck_t),
        .sdi(sdi_t), .busy(busy_t), .result_valid(val_t), .result_data(data_t));

    adc_link_ctrl #(.SCK_HALF(HALF), .CONV_CYCLES(CONV_P), .WARM_CYCLES(WARM), .USE_POLL(1'b1)) dut_poll_i (
        .clk(clk), .rst_n(rst_n), .start(start_p), .cfg_en1(en1), .cfg_en2(en2),
        .cfg_speed(spd), .cfg_sleep(slp), .sdo(sdo_p), .cs_n(cs_p), .sck(sck_p),
        .sdi(sdi_p), .busy(busy_p), .result_valid(val_p), .result_data(data_p));

    adc_link_periph_model #(.CONV_T(CONV_T), .POLL(1'b0), .HALF(HALF)) m_t (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_t), .sck(sck_t), .sdi(sdi_t), .word_in(word_t),
        .sdo(sdo_t), .exp_valid(ev_t), .exp_word(ew_t), .cfg_seen(cfg_t), .lead(lead_t),
        .bad_conv(bconv_t), .bad_half(bhalf_t));

    adc_link_periph_model #(.CONV_T(CONV_P), .POLL(1'b1), .HALF(HALF)) m_p (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_p), .sck(sck_p), .sdi(sdi_p), .word_in(word_p),
        .sdo(sdo_p), .exp_valid(ev_p), .exp_word(ew_p), .cfg_seen(cfg_p), .lead(lead_p),
        .bad_conv(bconv_p), .bad_half(bhalf_p));

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Per-clock comparison of the strobe and word against the reference model (R2).
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            check(val_t == ev_t, "R2", "timer strobe", val_t, ev_t);
            if (val_t) check(data_t == ew_t, "R2", "timer word", data_t, ew_t);
            check(val_p == ev_p, "R2", "poll strobe", val_p, ev_p);
            if (val_p) check(data_p == ew_p, "R2", "poll word", data_p, ew_p);
        end
    end

    // warm_exp: 0 none expected, 1 warm-up expected, 2 not checked
    task automatic run_frame(input bit poll, input bit e1, input bit e2, input bit s, input bit p,
                             input logic [15:0] w, input int warm_exp, input string lead_req,
                             input bit poke);
        int n;
        @(negedge clk);
        en1 = e1; en2 = e2; spd = s; slp = p;
        if (poll) begin word_p = w; start_p = 1'b1; end
        else      begin word_t = w; start_t = 1'b1; end
        @(negedge clk);
        start_p = 1'b0; start_t = 1'b0;
        n = 0;
        while (!(poll ? val_p : val_t) && n < 5000) begin
            @(negedge clk);
            n++;
            if (poke && n == 20) begin
                if (poll) start_p = 1'b1; else start_t = 1'b1;
                @(negedge clk);
                start_p = 1'b0; start_t = 1'b0;
                n++;
            end
        end
        #2;
        check(n < 5000, "R2", "frame completed", n, 0);
        check((poll ? data_p : data_t) == w, "R2", "result word", poll ? data_p : data_t, w);
        check((poll ? cs_p : cs_t) == 1'b1, "R2", "cs high with strobe", poll ? cs_p : cs_t, 1);
        check((poll ? cfg_p : cfg_t) == {e1, e2, s, p}, "R3", "config bits on wire",
              poll ? cfg_p : cfg_t, {e1, e2, s, p});
        if (warm_exp == 1)
            check((poll ? lead_p : lead_t) >= WARM, lead_req, "warm-up lead", poll ? lead_p : lead_t, WARM);
        else if (warm_exp == 0)
            check((poll ? lead_p : lead_t) < WARM, lead_req, "no warm-up lead", poll ? lead_p : lead_t, WARM);
        @(negedge clk);
        #2;
        check((poll ? val_p : val_t) == 1'b0, "R2", "strobe one cycle", poll ? val_p : val_t, 0);
        if (poke) begin
            repeat (5) @(negedge clk);
            #2;
            check((poll ? busy_p : busy_t) == 1'b0, "R9", "start during frame ignored",
                  poll ? busy_p : busy_t, 0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #2;
        // R1 reset state
        check(cs_t == 1'b1 && cs_p == 1'b1, "R1", "cs_n in reset", {cs_t, cs_p}, 3);
        check(sck_t == 1'b0 && sck_p == 1'b1, "R1", "sck idle level", {sck_t, sck_p}, 1);
        check(!busy_t && !busy_p && !val_t && !val_p, "R1", "busy/valid low",
              {busy_t, busy_p, val_t, val_p}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #2;
        check(cs_t == 1'b1 && sck_t == 1'b0 && !busy_t, "R1", "idle after reset", {cs_t, sck_t, busy_t}, 4);

        // Timer variant
        run_frame(1'b0, 1, 0, 0, 0, 16'hA5C3, 0, "R7", 1'b0);
        run_frame(1'b0, 1, 1, 0, 1, 16'h0001, 0, "R6", 1'b0); // rejected pair with sleep
        run_frame(1'b0, 1, 0, 0, 0, 16'hFFFF, 0, "R6", 1'b1); // no warm-up; start poked (R9)
        run_frame(1'b0, 1, 0, 0, 1, 16'h8000, 0, "R7", 1'b0); // sleep accepted
        run_frame(1'b0, 1, 0, 0, 0, 16'h7FFE, 1, "R7", 1'b0); // warm-up required
        run_frame(1'b0, 1, 0, 1, 1, 16'h0000, 0, "R8", 1'b0); // sleep at slow rate
        run_frame(1'b0, 1, 0, 0, 0, 16'h1234, 0, "R8", 1'b0); // still no warm-up

        // Poll variant
        run_frame(1'b1, 1, 0, 0, 0, 16'h8001, 2, "R5", 1'b0);
        run_frame(1'b1, 1, 0, 0, 1, 16'h0F0F, 2, "R5", 1'b0);
        run_frame(1'b1, 1, 0, 0, 0, 16'hC3A5, 1, "R7", 1'b0);

        repeat (4) @(negedge clk);
        #2;
        check(bconv_t == 0, "R4", "timer frames began after conversion", bconv_t, 0);
        check(bconv_p == 0, "R5", "no sck fall while converting", bconv_p, 0);
        check(bhalf_t == 0, "R10", "timer sck high phase length", bhalf_t, 0);
        check(bhalf_p == 0, "R10", "poll sck high phase length", bhalf_p, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule